// File: doc/BRIEF.md
# Debug System Bus Access Controller

This block lets a debugger reach system memory without halting a processor. Software sees three 32-bit registers: a control/status register, an address register and a data register. Accesses to those registers have side effects that launch single-beat transfers on a simple memory bus. That bus uses a request/grant handshake followed by one response beat, which carries read data and an error flag.

Writing the data register launches a bus write. Writing the address register launches a bus read when the read-on-address option is set. Reading the data register returns the held value and then launches the next bus read when the read-on-data option is set. Auto-increment steps the address by the access size after each access that completes cleanly, so a debugger can stream through memory. Bus errors, unsupported sizes and register writes that arrive while a transfer is in flight are recorded in sticky flags. Software clears these flags by writing 1 to them. While any flag is set, no new transfer starts.

The transfer engine is a three-state machine:
- IDLE waits for a trigger. The transition IDLE to REQ is called *launch*.
- REQ holds the request until the grant arrives. The transition REQ to RESP is called *granted*.
- RESP waits for the response beat. The transition RESP to IDLE is called *retire*.

Top module: `sba_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00070004: busy 0, size 2 in bits [3:1], all option bits 0, error field [10:8] = 0, busy-violation bit 12 = 0, capability bits [20:16] = 5'b00111. The address and data registers read 0.
- R2: A write to the data register (select 2) launches one bus write at the address register's value with size `s` (bits [3:1]). Byte enables are the `2^s` lanes containing the address, aligned to `2^s`. Each enabled lane carries the matching low byte of the written data, so memory holds exactly those bytes afterwards.
- R3: With read-on-address (bit 5) set, a write to the address register (select 1) launches a bus read. On retire, the data register holds the addressed `2^s` bytes zero-extended to 32 bits.
- R4: With auto-increment (bit 4) set, each access that retires without error adds `1 << s` to the address register.
- R5: With read-on-data (bit 6) set, reading the data register returns its current value and launches a read at the current address. With auto-increment also set, successive reads return consecutive locations.
- R6: A response with its error flag set writes 2 into the error field.
- R7: A trigger while the size field is 3 or 4 writes 3 into the error field, and no bus request is made.
- R8: A write to the address or data register while busy sets the busy-violation bit. The register keeps its old value.
- R9: Writing a nonzero value into the error field bits clears the field. Writing 1 to bit 12 clears the busy-violation bit. Writing 0 to either leaves it unchanged.
- R10: While the error field is nonzero or the busy-violation bit is set, no trigger launches a transfer.
- R11: Busy (bit 0) is high from launch until retire. The bus request stays high, with a stable address, until it is granted.
- R12: Capability bit `16+k` is 1 exactly when size `k` fits the 32-bit bus, that is for k = 0, 1, 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; only its side effect needs it |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register (combinational) |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_we | output | 1 | 1 for a write transfer |
| bus_addr | output | 32 | Byte address |
| bus_size | output | 3 | Access size, log2 of the byte count |
| bus_be | output | 4 | Byte-lane enables |
| bus_wdata | output | 32 | Write data, replicated across lanes |
| bus_rsp_valid | input | 1 | Response beat |
| bus_rsp_err | input | 1 | Response error flag |
| bus_rdata | input | 32 | Read data, full bus word |

## Verification
The bench builds the block with its defaults: a 32-bit address and a 32-bit data path. This makes sizes 0 to 2 legal and sizes 3 and 4 unsupported, so both the success path and the size-error path are reached. Every legal size is swept over sixteen addresses each, which covers every byte-lane position for writes and zero-extended reads. Streaming with auto-increment is checked at all three sizes. A stalling grant stretches the REQ state, so busy polling and register writes that collide with a transfer become observable.

// File: rtl/sba_pkg.sv
package sba_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_RESP = 2'd2
    } sba_state_t;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    localparam logic [2:0] ERR_NONE = 3'd0;
    localparam logic [2:0] ERR_BUS  = 3'd2;
    localparam logic [2:0] ERR_SIZE = 3'd3;

    localparam int B_BUSY   = 0;
    localparam int B_SIZE   = 1;
    localparam int B_AUTO   = 4;
    localparam int B_RDADDR = 5;
    localparam int B_RDDATA = 6;
    localparam int B_ERR    = 8;
    localparam int B_BERR   = 12;
    localparam int B_CAP    = 16;
    localparam int N_CAP    = 5;

endpackage

// File: rtl/sba_lane_unit.sv
module sba_lane_unit #(
    parameter int DATA_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic [SIZE_W-1:0]             size,
    input  logic [$clog2(DATA_W/8)-1:0]   lane_addr,
    input  logic [DATA_W-1:0]             wdata_in,
    input  logic [DATA_W-1:0]             rdata_in,
    output logic [DATA_W/8-1:0]           be,
    output logic [DATA_W-1:0]             wdata_out,
    output logic [DATA_W-1:0]             rdata_out
);
    localparam int LANES = DATA_W / 8;
    localparam int LAW   = $clog2(LANES);

    logic [LAW-1:0] lmask;
    logic [LAW-1:0] base;

    always_comb begin
        if (int'(size) >= LAW) lmask = '1;
        else                   lmask = (LAW'(1) << size) - LAW'(1);
        base = lane_addr & ~lmask;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [LAW-1:0] IDX = LAW'(i);
        logic [LAW-1:0] src_w;
        logic [LAW-1:0] src_r;
        always_comb begin
            src_w = IDX & lmask;
            src_r = base | IDX;
            be[i] = ((IDX & ~lmask) == base);
            wdata_out[8*i +: 8] = wdata_in[8*int'(src_w) +: 8];
            if ((IDX & ~lmask) == '0) rdata_out[8*i +: 8] = rdata_in[8*int'(src_r) +: 8];
            else                      rdata_out[8*i +: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/sba_bus_fsm.sv
module sba_bus_fsm
    import sba_pkg::*;
#(
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_we,
    input  logic [SIZE_W-1:0] start_size,
    input  logic              gnt,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    output logic              req,
    output logic              busy,
    output logic              done,
    output logic              done_err,
    output logic              cur_we,
    output logic [SIZE_W-1:0] cur_size
);
    sba_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start)     nxt = S_REQ;
            S_REQ:   if (gnt)       nxt = S_RESP;
            S_RESP:  if (rsp_valid) nxt = S_IDLE;
            default:                nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_we   <= 1'b0;
            cur_size <= '0;
        end else if (state == S_IDLE && start) begin
            cur_we   <= start_we;
            cur_size <= start_size;
        end
    end

    always_comb begin
        req      = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state)
            S_IDLE: busy = 1'b0;
            S_REQ:  req  = 1'b1;
            S_RESP: done = rsp_valid;
            default: busy = 1'b0;
        endcase
        done_err = done & rsp_err;
    end
endmodule

// File: rtl/sba_regfile.sv
module sba_regfile
    import sba_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              done_err,
    input  logic [DATA_W-1:0] done_rdata,
    input  logic              cur_we,
    input  logic [SIZE_W-1:0] cur_size,
    output logic              start,
    output logic              start_we,
    output logic [SIZE_W-1:0] start_size,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [2:0]        err_q,
    output logic              berr_q
);
    localparam int MAX_SZ = $clog2(DATA_W / 8);

    logic [SIZE_W-1:0] size_q;
    logic auto_q, rdaddr_q, rddata_q;
    logic wr_ctrl, wr_addr, wr_data, rd_data;
    logic can_start, trig_wr, trig_rd, trig, size_ok;

    always_comb begin
        wr_ctrl   = reg_wr && reg_sel == SEL_CTRL;
        wr_addr   = reg_wr && reg_sel == SEL_ADDR;
        wr_data   = reg_wr && reg_sel == SEL_DATA;
        rd_data   = reg_rd && reg_sel == SEL_DATA;
        can_start = !busy && err_q == ERR_NONE && !berr_q;
        trig_wr   = can_start && wr_data;
        trig_rd   = can_start && ((wr_addr && rdaddr_q) || (rd_data && rddata_q));
        trig      = trig_wr || trig_rd;
        size_ok   = int'(size_q) <= MAX_SZ;
        start     = trig && size_ok;
        start_we  = trig_wr;
        start_size = size_q;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CTRL: begin
                reg_rdata[B_BUSY]               = busy;
                reg_rdata[B_SIZE +: SIZE_W]     = size_q;
                reg_rdata[B_AUTO]               = auto_q;
                reg_rdata[B_RDADDR]             = rdaddr_q;
                reg_rdata[B_RDDATA]             = rddata_q;
                reg_rdata[B_ERR +: 3]           = err_q;
                reg_rdata[B_BERR]               = berr_q;
                for (int k = 0; k < N_CAP; k++)
                    reg_rdata[B_CAP + k] = (k <= MAX_SZ);
            end
            SEL_ADDR: reg_rdata[ADDR_W-1:0] = addr_q;
            SEL_DATA: reg_rdata = data_q;
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q   <= SIZE_W'(2);
            auto_q   <= 1'b0;
            rdaddr_q <= 1'b0;
            rddata_q <= 1'b0;
            err_q    <= ERR_NONE;
            berr_q   <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                size_q   <= reg_wdata[B_SIZE +: SIZE_W];
                auto_q   <= reg_wdata[B_AUTO];
                rdaddr_q <= reg_wdata[B_RDADDR];
                rddata_q <= reg_wdata[B_RDDATA];
                if (reg_wdata[B_ERR +: 3] != 3'd0) err_q <= ERR_NONE;
                if (reg_wdata[B_BERR])             berr_q <= 1'b0;
            end
            if (busy && (wr_addr || wr_data)) begin
                berr_q <= 1'b1;
            end else begin
                if (wr_addr) addr_q <= reg_wdata[ADDR_W-1:0];
                if (wr_data) data_q <= reg_wdata;
            end
            if (trig && !size_ok) err_q <= ERR_SIZE;
            if (done) begin
                if (done_err) begin
                    err_q <= ERR_BUS;
                end else begin
                    if (!cur_we) data_q <= done_rdata;
                    if (auto_q)  addr_q <= addr_q + (ADDR_W'(1) << cur_size);
                end
            end
        end
    end
endmodule

// File: rtl/sba_ctrl.sv
module sba_ctrl
    import sba_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [1:0]           reg_sel,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 bus_req,
    input  logic                 bus_gnt,
    output logic                 bus_we,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [SIZE_W-1:0]    bus_size,
    output logic [DATA_W/8-1:0]  bus_be,
    output logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_rsp_valid,
    input  logic                 bus_rsp_err,
    input  logic [DATA_W-1:0]    bus_rdata
);
    localparam int LAW = $clog2(DATA_W / 8);

    logic              busy_w, done_w, done_err_w, start_w, start_we_w, cur_we_w;
    logic [SIZE_W-1:0] start_size_w, cur_size_w;
    logic [DATA_W-1:0] rd_ext_w, data_w;
    logic [ADDR_W-1:0] addr_w;
    logic [2:0]        err_w;
    logic              berr_w;

    sba_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy_w), .done(done_w), .done_err(done_err_w), .done_rdata(rd_ext_w),
        .cur_we(cur_we_w), .cur_size(cur_size_w),
        .start(start_w), .start_we(start_we_w), .start_size(start_size_w),
        .addr_q(addr_w), .data_q(data_w), .err_q(err_w), .berr_q(berr_w)
    );

    sba_bus_fsm #(.SIZE_W(SIZE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(start_w), .start_we(start_we_w), .start_size(start_size_w),
        .gnt(bus_gnt), .rsp_valid(bus_rsp_valid), .rsp_err(bus_rsp_err),
        .req(bus_req), .busy(busy_w), .done(done_w), .done_err(done_err_w),
        .cur_we(cur_we_w), .cur_size(cur_size_w)
    );

    sba_lane_unit #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_lanes (
        .size(cur_size_w), .lane_addr(addr_w[LAW-1:0]),
        .wdata_in(data_w), .rdata_in(bus_rdata),
        .be(bus_be), .wdata_out(bus_wdata), .rdata_out(rd_ext_w)
    );

    assign bus_we   = cur_we_w;
    assign bus_addr = addr_w;
    assign bus_size = cur_size_w;
endmodule

// File: rtl/sba_ctrl_checker.sv
module sba_ctrl_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [1:0]          reg_sel,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic                bus_req,
    input logic                bus_gnt,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [SIZE_W-1:0]   bus_size,
    input logic [DATA_W/8-1:0] bus_be,
    input logic                bus_rsp_valid,
    input logic                bus_rsp_err,
    input logic                busy,
    input logic [2:0]          err_code,
    input logic                busy_err
);
    localparam int MAX_SZ = $clog2(DATA_W / 8);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_addr));

    p_be_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> $countones(bus_be) == (1 << bus_size));

    p_size_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> int'(bus_size) <= MAX_SZ);

    p_bus_err_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bus_req && bus_rsp_valid && bus_rsp_err |=> err_code == 3'd2);

    p_busy_viol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && reg_wr && (reg_sel == 2'd1 || reg_sel == 2'd2) |=> busy_err);

    p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && (err_code != 3'd0 || busy_err) |=> !busy);

    p_berr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err && !(reg_wr && reg_sel == 2'd0 && reg_wdata[12]) |=> busy_err);
endmodule

bind sba_ctrl sba_ctrl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_be(bus_be), .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
    .busy(busy_w), .err_code(err_w), .busy_err(berr_w)
);

// File: tb/tb_sba_ctrl.sv
module tb_sba_ctrl;
    localparam logic [31:0] BASE = 32'h8000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic bus_req, bus_gnt, bus_we, bus_rsp_valid = 1'b0, bus_rsp_err = 1'b0;
    logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
    logic [2:0] bus_size;
    logic [3:0] bus_be;

    int tests = 0, fails = 0, xfers = 0;
    logic stall = 1'b0;
    logic [1:0] cyc = '0;
    logic [3:0] last_be = '0;
    logic [7:0] bmem [0:255];
    logic [7:0] tmem [0:255];

    sba_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
        .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    assign bus_gnt = bus_req && (!stall || cyc == 2'b11);

    always @(posedge clk) begin
        cyc <= cyc + 2'd1;
        bus_rsp_valid <= 1'b0;
        bus_rsp_err   <= 1'b0;
        if (bus_req && bus_gnt) begin
            xfers <= xfers + 1;
            last_be <= bus_be;
            bus_rsp_valid <= 1'b1;
            if (bus_addr[31:8] != BASE[31:8]) begin
                bus_rsp_err <= 1'b1;
            end else if (bus_we) begin
                for (int b = 0; b < 4; b++)
                    if (bus_be[b]) bmem[{bus_addr[7:2], 2'(b)}] <= bus_wdata[8*b +: 8];
            end else begin
                for (int b = 0; b < 4; b++)
                    bus_rdata[8*b +: 8] <= bmem[{bus_addr[7:2], 2'(b)}];
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual=hung expected=idle");
        summary();
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, logic pulse, output logic [31:0] v);
        @(negedge clk);
        reg_sel = sel; reg_rd = pulse;
        #1 v = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        do rd(2'd0, 1'b0, v); while (v[0]);
    endtask

    function automatic logic [31:0] mkctrl(int s, bit ai, bit roa, bit rod, bit ce, bit cb);
        logic [31:0] c = '0;
        c[3:1] = 3'(s); c[4] = ai; c[5] = roa; c[6] = rod;
        c[10:8] = ce ? 3'd7 : 3'd0; c[12] = cb;
        return c;
    endfunction

    function automatic logic [31:0] expect_rd(logic [7:0] off, int s);
        logic [31:0] r = '0;
        for (int b = 0; b < (1 << s); b++) r[8*b +: 8] = tmem[off + 8'(b)];
        return r;
    endfunction

    task automatic shadow_wr(logic [7:0] off, int s, logic [31:0] d);
        for (int b = 0; b < (1 << s); b++) tmem[off + 8'(b)] = d[8*b +: 8];
    endtask

    initial begin
        logic [31:0] v, pat;
        logic [7:0] off;
        int x0;
        for (int k = 0; k < 256; k++) begin bmem[k] = 8'h00; tmem[k] = 8'h00; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 / R12 reset state and capabilities
        rd(2'd0, 1'b0, v); check("R1 ctrl reset", v, 32'h0007_0004);
        check("R12 capability", {27'b0, v[20:16]}, 32'h7);
        rd(2'd1, 1'b0, v); check("R1 addr reset", v, 32'h0);
        rd(2'd2, 1'b0, v); check("R1 data reset", v, 32'h0);

        // R2 writes of every legal size and lane position
        for (int s = 0; s < 3; s++) begin
            wr(2'd0, mkctrl(s, 0, 0, 0, 0, 0));
            for (int i = 0; i < 16; i++) begin
                off = 8'(s * 64 + (i << s));
                pat = 32'hF0E1_D2C3 ^ (32'(i) * 32'h0101_0101);
                wr(2'd1, BASE + 32'(off));
                wr(2'd2, pat);
                wait_idle();
                shadow_wr(off, s, pat);
                check("R2 byte enables", {28'b0, last_be},
                      32'((((1 << (1 << s)) - 1) << (off[1:0]))));
            end
        end
        // R3 readback, zero-extended
        for (int s = 0; s < 3; s++) begin
            wr(2'd0, mkctrl(s, 0, 1, 0, 0, 0));
            for (int i = 0; i < 16; i++) begin
                off = 8'(s * 64 + (i << s));
                wr(2'd1, BASE + 32'(off));
                wait_idle();
                rd(2'd2, 1'b0, v);
                check("R3 read data", v, expect_rd(off, s));
            end
        end

        // R4 / R5 auto-increment write then streamed reads
        for (int s = 0; s < 3; s++) begin
            wr(2'd0, mkctrl(s, 1, 0, 0, 0, 0));
            wr(2'd1, BASE + 32'hC0);
            for (int k = 0; k < 8; k++) begin
                pat = 32'h1357_9BDF + 32'(k * 16 + s);
                wr(2'd2, pat);
                wait_idle();
                shadow_wr(8'(8'hC0 + (k << s)), s, pat);
            end
            rd(2'd1, 1'b0, v);
            check("R4 address advanced", v, BASE + 32'hC0 + 32'(8 << s));
            wr(2'd0, mkctrl(s, 1, 1, 1, 0, 0));
            wr(2'd1, BASE + 32'hC0);
            wait_idle();
            for (int k = 0; k < 8; k++) begin
                rd(2'd2, 1'b1, v);
                check("R5 streamed read", v, expect_rd(8'(8'hC0 + (k << s)), s));
                wait_idle();
            end
        end

        // R11 busy visible and request held under a stalling grant
        stall = 1'b1;
        wr(2'd0, mkctrl(2, 0, 0, 0, 0, 0));
        wr(2'd1, BASE + 32'h10);
        wr(2'd2, 32'hCAFE_0001);
        rd(2'd0, 1'b0, v); check("R11 busy after launch", {31'b0, v[0]}, 32'h1);
        wait_idle();
        shadow_wr(8'h10, 2, 32'hCAFE_0001);
        // R8 collision while busy
        wr(2'd2, 32'hCAFE_0002);
        wr(2'd1, BASE + 32'h44);
        wait_idle();
        rd(2'd0, 1'b0, v); check("R8 busy violation set", {31'b0, v[12]}, 32'h1);
        rd(2'd1, 1'b0, v); check("R8 address kept", v, BASE + 32'h10);
        shadow_wr(8'h10, 2, 32'hCAFE_0002);
        stall = 1'b0;
        // R10 no launch while violation flag set
        x0 = xfers;
        wr(2'd2, 32'h1111_2222);
        repeat (4) @(negedge clk);
        check("R10 held off by busy flag", 32'(xfers - x0), 32'h0);
        // R9 writing 0 keeps, writing 1 clears
        wr(2'd0, mkctrl(2, 0, 0, 0, 0, 0));
        rd(2'd0, 1'b0, v); check("R9 zero write keeps flag", {31'b0, v[12]}, 32'h1);
        wr(2'd0, mkctrl(2, 0, 0, 0, 0, 1));
        rd(2'd0, 1'b0, v); check("R9 flag cleared", {31'b0, v[12]}, 32'h0);

        // R6 bus error on unmapped address
        wr(2'd0, mkctrl(2, 1, 1, 0, 0, 0));
        wr(2'd1, 32'h0000_1000);
        wait_idle();
        rd(2'd0, 1'b0, v); check("R6 error field", {29'b0, v[10:8]}, 32'h2);
        rd(2'd1, 1'b0, v); check("R4 no step on error", v, 32'h0000_1000);
        x0 = xfers;
        wr(2'd1, BASE);
        repeat (4) @(negedge clk);
        check("R10 held off by error", 32'(xfers - x0), 32'h0);
        wr(2'd0, mkctrl(2, 0, 0, 0, 0, 0));
        rd(2'd0, 1'b0, v); check("R9 zero write keeps error", {29'b0, v[10:8]}, 32'h2);
        wr(2'd0, mkctrl(2, 0, 0, 0, 1, 0));
        rd(2'd0, 1'b0, v); check("R9 error cleared", {29'b0, v[10:8]}, 32'h0);

        // R7 unsupported sizes
        for (int s = 3; s < 5; s++) begin
            x0 = xfers;
            wr(2'd0, mkctrl(s, 0, 0, 0, 0, 0));
            wr(2'd2, 32'hDEAD_0000);
            repeat (4) @(negedge clk);
            rd(2'd0, 1'b0, v); check("R7 size error", {29'b0, v[10:8]}, 32'h3);
            check("R7 no transfer", 32'(xfers - x0), 32'h0);
            wr(2'd0, mkctrl(2, 0, 0, 0, 1, 0));
        end
        check("R2 memory intact", {bmem[8'h13], bmem[8'h12], bmem[8'h11], bmem[8'h10]},
              expect_rd(8'h10, 2));

        summary();
    end
endmodule